// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product in a single combinational pass. `WIDTH` must be a power of two and at least 2. The default is 8.

The product is built by recursion. Each level splits both operands into a high half and a low half. It forms the four half-width cross products in parallel, one from each smaller copy of the same structure. It then merges them with a fixed adder arrangement:

- a full-width carry-lookahead adder sums the two crosswise products;
- a second full-width carry-lookahead adder adds that sum to a word made from the high-high product's low half over the low-low product's high half;
- a half adder folds the two carries from those adders;
- a half-width carry-lookahead adder places the folded carries onto the high-high product's upper half.

The recursion ends at a 2-bit cell. That cell takes its two vertical partial products (bit 0 × bit 0, bit 1 × bit 1) and its two crosswise ones (bit 1 × bit 0, bit 0 × bit 1) all at once.

The block holds no state and needs no clock. It is meant to sit in a wider arithmetic path where the product is registered by the surrounding logic.

Top module: `vcMultiplier`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product `opA * opB`, zero-extended to `2*WIDTH` bits.
- R2: With `WIDTH` = 2, the base cell alone gives the correct 4-bit result for all 16 operand pairs (for example 3 × 3 gives 4'b1001).
- R3: The half-width adder that forms the top quarter of the product never produces a carry out at any recursion level, including at the largest operands.
- R4: If either operand is zero, `product` is zero.
- R5: If either operand equals 1, `product` equals the other operand.
- R6: All-ones times all-ones gives 2^(2·WIDTH) − 2^(WIDTH+1) + 1 (16'hFE01 at `WIDTH` = 8).
- R7: If each operand has exactly one bit set, at positions i and j, then `product` has exactly one bit set, at position i+j.
- R8: With `WIDTH` = 4, `product` is correct for all 256 operand pairs, so every path through one level of recursion above the base cell is covered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product of opA and opB |

## Verification
The checker runs on every change of the operands. It compares `product` with the built-in multiply (R1). It confirms that the OR of the carry outs from every level's top-quarter adder stays low (R3). It also checks the zero-operand, unit-operand and single-bit cases (R4, R5, R7).

Some properties cannot be shown by an assertion on one instance. The base cell working alone (R2) and the complete coverage of one recursion level (R8) depend on the configuration. The bench shows these with sweeps over instances of width 2 and 4, next to a full sweep of the 8-bit default.

// File: rtl/vcMulPkg.sv
package vcMulPkg;
  typedef struct packed {
    logic carry;
    logic sum;
  } halfAdd_t;

  function automatic halfAdd_t halfAdd(input logic x, input logic y);
    halfAdd_t r;
    r.sum   = x ^ y;
    r.carry = x & y;
    return r;
  endfunction
endpackage

// File: rtl/vcCla.sv
module vcCla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen  = x & y;
  assign prop = x ^ y;

  // Each carry is a flat sum of products over generate/propagate terms.
  always_comb begin
    carry[0] = cin;
    for (int i = 0; i < W; i++) begin
      logic term;
      logic acc;
      acc  = gen[i];
      term = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc  = acc | (term & gen[j]);
        term = term & prop[j];
      end
      carry[i+1] = acc | (term & cin);
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/vcBaseCell.sv
module vcBaseCell (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  import vcMulPkg::*;
  logic vertLo;
  logic vertHi;
  logic crossA;
  logic crossB;
  halfAdd_t midStage;
  halfAdd_t topStage;

  // Vertical and crosswise partial products, all formed at once.
  assign vertLo = a[0] & b[0];
  assign vertHi = a[1] & b[1];
  assign crossA = a[1] & b[0];
  assign crossB = a[0] & b[1];

  assign midStage = halfAdd(crossA, crossB);
  assign topStage = halfAdd(vertHi, midStage.carry);

  assign p = {topStage.carry, topStage.sum, midStage.sum, vertLo};
endmodule

// File: rtl/vcCombine.sv
module vcCombine #(
  parameter int W = 4
) (
  input  logic [W-1:0]   pLoLo,
  input  logic [W-1:0]   pHiLo,
  input  logic [W-1:0]   pLoHi,
  input  logic [W-1:0]   pHiHi,
  output logic [2*W-1:0] p,
  output logic           topCarry
);
  import vcMulPkg::*;
  localparam int H = W / 2;

  logic [W-1:0] crossSum;
  logic         crossCarry;
  logic [W-1:0] midWord;
  logic [W-1:0] midSum;
  logic         midCarry;
  halfAdd_t     carryFold;
  logic [H-1:0] foldWord;
  logic [H-1:0] topSum;

  vcCla #(.W(W)) uCross (
    .x(pHiLo), .y(pLoHi), .cin(1'b0), .sum(crossSum), .cout(crossCarry)
  );

  assign midWord = {pHiHi[H-1:0], pLoLo[W-1:H]};

  vcCla #(.W(W)) uMid (
    .x(crossSum), .y(midWord), .cin(1'b0), .sum(midSum), .cout(midCarry)
  );

  assign carryFold = halfAdd(crossCarry, midCarry);
  assign foldWord  = {{(H-2){1'b0}}, carryFold.carry, carryFold.sum};

  vcCla #(.W(H)) uTop (
    .x(pHiHi[W-1:H]), .y(foldWord), .cin(1'b0), .sum(topSum), .cout(topCarry)
  );

  assign p = {topSum, midSum, pLoLo[H-1:0]};
endmodule

// File: rtl/vcMulCore.sv
module vcMulCore #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p,
  output logic           anyTopCarry
);
  localparam int H = W / 2;

  generate
    if (W == 2) begin : gBase
      vcBaseCell uCell (.a(a), .b(b), .p(p));
      assign anyTopCarry = 1'b0;
    end else begin : gSplit
      logic [W-1:0] pLoLo, pHiLo, pLoHi, pHiHi;
      logic [3:0]   subCarry;
      logic         levelCarry;

      vcMulCore #(.W(H)) uLoLo (.a(a[H-1:0]), .b(b[H-1:0]), .p(pLoLo), .anyTopCarry(subCarry[0]));
      vcMulCore #(.W(H)) uHiLo (.a(a[W-1:H]), .b(b[H-1:0]), .p(pHiLo), .anyTopCarry(subCarry[1]));
      vcMulCore #(.W(H)) uLoHi (.a(a[H-1:0]), .b(b[W-1:H]), .p(pLoHi), .anyTopCarry(subCarry[2]));
      vcMulCore #(.W(H)) uHiHi (.a(a[W-1:H]), .b(b[W-1:H]), .p(pHiHi), .anyTopCarry(subCarry[3]));

      vcCombine #(.W(W)) uJoin (
        .pLoLo(pLoLo), .pHiLo(pHiLo), .pLoHi(pLoHi), .pHiHi(pHiHi),
        .p(p), .topCarry(levelCarry)
      );

      assign anyTopCarry = levelCarry | (|subCarry);
    end
  endgenerate
endmodule

// File: rtl/vcMultiplier.sv
module vcMultiplier #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);
  logic quarterCarry;

  vcMulCore #(.W(WIDTH)) uCore (
    .a(opA), .b(opB), .p(product), .anyTopCarry(quarterCarry)
  );
endmodule

// File: rtl/vcMultiplier_chk.sv
module vcMultiplier_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [2*WIDTH-1:0] product,
  input logic               quarterCarry
);
  localparam int PW = 2 * WIDTH;

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      assert_product_R1: assert (product == PW'(opA) * PW'(opB));
      assert_no_overflow_R3: assert (!quarterCarry);
      if (opA == '0 || opB == '0) begin
        assert_zero_R4: assert (product == '0);
      end
      if (opA == WIDTH'(1)) begin
        assert_unit_a_R5: assert (product == PW'(opB));
      end
      if (opB == WIDTH'(1)) begin
        assert_unit_b_R5: assert (product == PW'(opA));
      end
      if ($countones(opA) == 1 && $countones(opB) == 1) begin
        assert_onehot_R7: assert ($countones(product) == 1);
      end
    end
  end
endmodule

bind vcMultiplier vcMultiplier_chk #(.WIDTH(WIDTH)) uChk (
  .opA(opA), .opB(opB), .product(product), .quarterCarry(quarterCarry)
);

// File: tb/vcMultiplier_test.sv
module vcMultiplier_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;

  vcMultiplier #(.WIDTH(8)) uut  (.opA(a8), .opB(b8), .product(p8));
  vcMultiplier #(.WIDTH(4)) uut4 (.opA(a4), .opB(b4), .product(p4));
  vcMultiplier #(.WIDTH(2)) uut2 (.opA(a2), .opB(b2), .product(p2));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a8=%0d b8=%0d a4=%0d b4=%0d a2=%0d b2=%0d got=%h exp=%h",
               req, a8, b8, a4, b4, a2, b2, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    a8 = x; b8 = y;
    @(negedge clk);
  endtask

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
    @(negedge clk);
    check("R4 initial zero operands", p8, 16'h0000);

    // R2: base cell exhaustive
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        @(posedge clk);
        a2 = 2'(i); b2 = 2'(j);
        @(negedge clk);
        check("R2 base cell", {12'h000, p2}, 16'(i * j));
      end
    end

    // R8: one recursion level, exhaustive
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        a4 = 4'(i); b4 = 4'(j);
        @(negedge clk);
        check("R8 width4 sweep", {8'h00, p4}, 16'(i * j));
      end
    end

    // R1/R4/R5: full 8-bit sweep
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(8'(i), 8'(j));
        if (i == 0 || j == 0)      check("R4 zero operand", p8, 16'h0000);
        else if (i == 1)           check("R5 unit opA", p8, 16'(j));
        else if (j == 1)           check("R5 unit opB", p8, 16'(i));
        else                       check("R1 product", p8, 16'(i * j));
      end
    end

    // R6 and R3: largest operands
    apply(8'hFF, 8'hFF);
    check("R6 all ones", p8, 16'hFE01);
    check("R3 no top carry at max operands", p8, 16'(255 * 255));
    apply(8'hFF, 8'h80);
    check("R3 max times msb", p8, 16'h7F80);

    // R7: single set bits
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(8'(1 << i), 8'(1 << j));
        check("R7 single bits", p8, 16'(1 << (i + j)));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule